// File: doc/BRIEF.md
# Parallel First-Order Carrier Phase Loop

This block tracks the carrier phase of a QPSK stream that arrives as LANES phase samples per clock. Each sample is compared with one shared phase reference, which is the oscillator phase left by the last sample of the previous block. The comparison discards the symbol information by folding the difference into one quadrant. The folded errors are centred, accumulated across lanes by prefix sums, scaled by a power-of-two gain and added to the reference to give a phase estimate for every lane. Because every lane measures against the same stored reference, the only value carried from block to block is a single phase word, and the critical feedback path is one multi-operand addition rather than a chain of per-sample updates.

Phases are unsigned PW-bit words in which the full circle spans 2^PW codes, so a quadrant is 2^(PW-2) codes and an eighth of a turn is Q = 2^(PW-3) codes. The gain is 2^-KSH. Alongside each estimate the block also outputs the derotated phase of the lane, the received phase minus the estimate for the sample before it. This result is an approximation of the serial loop that is valid for small gains and small frequency offsets, and it is the intended behaviour.

Top module: `ploop_par1`

## Requirements
- R1: While rst_n is low and after its release until the first accepted block, out_vld is 0, every lane of nco_phase and rot_phase is 0, and the stored reference is 0.
- R2: out_vld in a cycle equals in_vld of the cycle before, and the results of a block accepted at one clock edge appear on the outputs right after that edge.
- R3: Lane m takes its phase from in_phase bits [m*PW +: PW]. Its error is e_m = ((in_phase_m − ref) mod 2^(PW-2)) − Q, a signed value in [−Q, Q).
- R4: The estimate of lane m is nco_m = (ref + floor((e_0 + … + e_m) / 2^KSH)) mod 2^PW, placed at nco_phase bits [m*PW +: PW].
- R5: On each accepted block the reference becomes the estimate of the last lane; it is kept unchanged in cycles with in_vld low.
- R6: The derotated phase of lane m is (in_phase_m − nco_{m−1}) mod 2^PW, with the stored reference taking the place of nco_{−1} for lane 0; placed at rot_phase bits [m*PW +: PW].
- R7: In cycles with in_vld low the in_phase value has no effect: nco_phase and rot_phase keep their values.
- R8: Estimates of neighbouring lanes differ, taken as a signed PW-bit difference, by at most Q/2^KSH + 1 codes.
- R9: All phase sums wrap modulo 2^PW, so a reference that climbs past 2^PW−1 continues from 0.
- R10: A lane whose phase equals the reference plus a whole number of quadrants has error −Q; one at the reference plus Q has error 0 and leaves the estimate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | A block of LANES phases is present |
| in_phase | input | LANES*PW | Received phases, lane 0 in the low word |
| out_vld | output | 1 | Results of an accepted block are present |
| nco_phase | output | LANES*PW | Per-lane oscillator phase estimates |
| rot_phase | output | LANES*PW | Per-lane derotated phases |

## Verification
Blocks with every lane at the reference and every lane a quadrant-eighth above it isolate the folding and centring of the error: the first walks the estimate down by a known ramp, the second must leave it flat. A steady phase ramp across lanes and blocks imitates a frequency offset and tells apart an error that is measured against the shared reference from one chained through the lanes, while a run of maximum positive errors drives the reference through the top of the circle to expose a missing wrap. Random blocks separated by idle cycles with changing inputs confirm that the reference and outputs move only on accepted blocks.

// File: rtl/ploop_pkg.sv
package ploop_pkg;
  localparam int unsigned LANES_DEF = 16;
  localparam int unsigned PW_DEF    = 16;
  localparam int unsigned KSH_DEF   = 4;

  // One eighth of the circle in a pw-bit phase word.
  function automatic int unsigned eighth_turn(input int unsigned pw);
    return 32'd1 << (pw - 3);
  endfunction

  // Centring offset applied after summing lanes 0..m.
  function automatic int unsigned lane_offset(input int unsigned m, input int unsigned pw);
    return (m + 1) * eighth_turn(pw);
  endfunction
endpackage

// File: rtl/ploop_lane_err.sv
module ploop_lane_err #(
  parameter int unsigned PW = ploop_pkg::PW_DEF
) (
  input  logic [PW-1:0] phase_i,
  input  logic [PW-1:0] ref_i,
  output logic [PW-3:0] dist_o
);
  localparam int unsigned DW = PW - 2;

  // Distance to the reference folded into one quadrant.
  always_comb dist_o = DW'(phase_i - ref_i);
endmodule

// File: rtl/ploop_prefix.sv
module ploop_prefix #(
  parameter int unsigned LANES = ploop_pkg::LANES_DEF,
  parameter int unsigned PW    = ploop_pkg::PW_DEF,
  parameter int unsigned KSH   = ploop_pkg::KSH_DEF
) (
  input  logic [LANES*(PW-2)-1:0] dist_i,
  input  logic [PW-1:0]           ref_i,
  output logic [LANES*PW-1:0]     nco_o
);
  localparam int unsigned DW = PW - 2;
  localparam int unsigned SW = DW + $clog2(LANES) + 2;

  for (genvar m = 0; m < LANES; m++) begin : g_sum
    localparam logic signed [SW-1:0] OFS = SW'(ploop_pkg::lane_offset(m, PW));
    logic [SW-1:0]        acc;
    logic signed [SW-1:0] cen;

    // Multi-operand sum of lanes 0..m, left to the tool to build as a tree.
    always_comb begin
      acc = '0;
      for (int k = 0; k <= m; k++) acc = acc + SW'(dist_i[k*DW +: DW]);
    end

    always_comb begin
      cen = $signed(acc) - OFS;
      nco_o[m*PW +: PW] = ref_i + PW'(cen >>> KSH);
    end
  end
endmodule

// File: rtl/ploop_par1.sv
module ploop_par1 #(
  parameter int unsigned LANES = ploop_pkg::LANES_DEF,
  parameter int unsigned PW    = ploop_pkg::PW_DEF,
  parameter int unsigned KSH   = ploop_pkg::KSH_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [LANES*PW-1:0] in_phase,
  output logic                out_vld,
  output logic [LANES*PW-1:0] nco_phase,
  output logic [LANES*PW-1:0] rot_phase
);
  localparam int unsigned DW   = PW - 2;
  localparam int unsigned LAST = LANES - 1;
  localparam logic signed [PW-1:0] STEP_LIM =
    PW'((ploop_pkg::eighth_turn(PW) >> KSH) + 1);

  logic [PW-1:0]         ref_q;
  logic [LANES*DW-1:0]   dist_w;
  logic [LANES*PW-1:0]   nco_w;
  logic [LANES*PW-1:0]   rot_w;
  logic [PW-1:0]         next_ref_w;
  logic                  blk_accept_w;

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    ploop_lane_err #(.PW(PW)) u_err (
      .phase_i (in_phase[m*PW +: PW]),
      .ref_i   (ref_q),
      .dist_o  (dist_w[m*DW +: DW])
    );
  end

  ploop_prefix #(.LANES(LANES), .PW(PW), .KSH(KSH)) u_prefix (
    .dist_i (dist_w),
    .ref_i  (ref_q),
    .nco_o  (nco_w)
  );

  for (genvar m = 0; m < LANES; m++) begin : g_rot
    if (m == 0) begin : g_first
      always_comb rot_w[PW-1:0] = in_phase[PW-1:0] - ref_q;
    end else begin : g_rest
      always_comb rot_w[m*PW +: PW] = in_phase[m*PW +: PW] - nco_w[(m-1)*PW +: PW];
    end
  end

  assign next_ref_w   = nco_w[LAST*PW +: PW];
  assign blk_accept_w = in_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      ref_q     <= '0;
      nco_phase <= '0;
      rot_phase <= '0;
    end else begin
      out_vld <= blk_accept_w;
      if (blk_accept_w) begin
        ref_q     <= next_ref_w;
        nco_phase <= nco_w;
        rot_phase <= rot_w;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_idle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(ref_q) && $stable(nco_phase) && $stable(rot_phase)));
  assert_ref_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q == nco_phase[LAST*PW +: PW]);
  assert_rot_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (PW'(rot_phase[PW-1:0] + $past(ref_q)) == $past(in_phase[PW-1:0])));

  for (genvar m = 1; m < LANES; m++) begin : g_chk
    logic signed [PW-1:0] step_w;
    assign step_w = nco_phase[m*PW +: PW] - nco_phase[(m-1)*PW +: PW];
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (step_w <= STEP_LIM && step_w >= -STEP_LIM));
    assert_rot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (PW'(rot_phase[m*PW +: PW] + nco_phase[(m-1)*PW +: PW])
                   == $past(in_phase[m*PW +: PW])));
  end
endmodule

// File: tb/ploop_par1_tb.sv
`timescale 1ns/1ps
module ploop_par1_tb_top;
  localparam int LANES = 16;
  localparam int PW    = 16;
  localparam int KSH   = 4;
  localparam int FULL  = 1 << PW;
  localparam int QUAD  = 1 << (PW - 2);
  localparam int Q     = 1 << (PW - 3);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_vld = 1'b0;
  logic [LANES*PW-1:0] in_phase = '0;
  logic                out_vld;
  logic [LANES*PW-1:0] nco_phase;
  logic [LANES*PW-1:0] rot_phase;

  int n_run = 0;
  int n_fail = 0;
  int mref = 0;
  int ph [LANES];
  int nco_e [LANES];
  int rot_e [LANES];
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ploop_par1 #(.LANES(LANES), .PW(PW), .KSH(KSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_phase(in_phase),
    .out_vld(out_vld), .nco_phase(nco_phase), .rot_phase(rot_phase)
  );

  function automatic int wrapf(input int v);
    return ((v % FULL) + FULL) % FULL;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench model: signed errors accumulated lane by lane, floor by shift.
  task automatic model_block();
    int acc = 0;
    int prev = mref;
    for (int m = 0; m < LANES; m++) begin
      int e = (wrapf(ph[m] - mref) % QUAD) - Q;
      acc += e;
      nco_e[m] = wrapf(mref + (acc >>> KSH));
      rot_e[m] = wrapf(ph[m] - prev);
      prev = nco_e[m];
    end
    mref = nco_e[LANES-1];
  endtask

  task automatic send_block(input string tag);
    @(negedge clk);
    for (int m = 0; m < LANES; m++) in_phase[m*PW +: PW] = PW'(ph[m]);
    in_vld = 1'b1;
    model_block();
    @(posedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    chk(out_vld == 1'b1, "R2", {tag, " out_vld"}, int'(out_vld), 1);
    for (int m = 0; m < LANES; m++) begin
      int a = int'(nco_phase[m*PW +: PW]);
      chk(a == nco_e[m], (m == 0) ? "R3" : "R4", {tag, " nco"}, a, nco_e[m]);
      a = int'(rot_phase[m*PW +: PW]);
      chk(a == rot_e[m], "R6", {tag, " rot"}, a, rot_e[m]);
      if (m > 0) begin
        int s = int'($signed(PW'(nco_phase[m*PW +: PW] - nco_phase[(m-1)*PW +: PW])));
        chk(s <= (Q >> KSH) + 1 && s >= -((Q >> KSH) + 1), "R8", {tag, " step"}, s, Q >> KSH);
      end
    end
  endtask

  task automatic idle_cycles(input int n);
    logic [LANES*PW-1:0] n0, r0;
    n0 = nco_phase;
    r0 = rot_phase;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      for (int m = 0; m < LANES; m++) in_phase[m*PW +: PW] = PW'($urandom);
      @(posedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "R2", "idle out_vld", int'(out_vld), 0);
      chk(nco_phase == n0 && rot_phase == r0, "R7", "idle hold", 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0 && nco_phase == '0 && rot_phase == '0, "R1", "in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0 && nco_phase == '0 && rot_phase == '0, "R1", "after reset", 0, 0);

    // R1/R10: all lanes at reference 0 -> error -Q each.
    for (int m = 0; m < LANES; m++) ph[m] = 0;
    send_block("R10 zero");
    // R10: lanes at ref + Q -> zero error, estimate flat.
    for (int m = 0; m < LANES; m++) ph[m] = wrapf(mref + Q);
    send_block("R10 centre");
    for (int m = 0; m < LANES; m++) ph[m] = wrapf(mref + 3 * QUAD);
    send_block("R10 quadrant");

    // R5: idle with changing inputs, then a block must use the held reference.
    idle_cycles(3);
    for (int m = 0; m < LANES; m++) ph[m] = wrapf(mref + Q + 37 * m);
    send_block("R5 after idle");

    // Frequency-offset ramp over several blocks.
    for (int b = 0; b < 6; b++) begin
      for (int m = 0; m < LANES; m++) ph[m] = wrapf((b * LANES + m) * 300 + Q);
      send_block("R4 ramp");
    end

    // R9: maximum positive error pushes reference through 2^PW.
    for (int b = 0; b < 12; b++) begin
      for (int m = 0; m < LANES; m++) ph[m] = wrapf(mref + 2 * Q - 1 + QUAD * (m % 4));
      send_block("R9 wrap");
    end

    // Random blocks with random idle gaps.
    for (int b = 0; b < 40; b++) begin
      for (int m = 0; m < LANES; m++) ph[m] = int'($urandom % FULL);
      send_block("R4 random");
      if ($urandom % 3 == 0) idle_cycles(1 + int'($urandom % 2));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end
endmodule